// File: doc/BRIEF.md
# Masked Pattern-Match Interrupt Logic

This block watches an 8-bit input port and raises an interrupt when the port shows a pattern the host has set up. The port is first passed through a per-bit inversion stage. Each bit then gets its own condition from three host registers: the bit can be ignored, it can be required to sit at a level, or it can be required to make a transition. A match mode register decides how the per-bit conditions combine. In AND mode every specified bit must hold in the same sample. In OR mode one specified bit is enough.

A match sets a sticky pending flag. The host clears the flag with an acknowledge pulse. When the flag is set, a vector is captured. The vector joins the upper bits of a host-written base with a 4-bit source code, so one block can supply 16 distinct vectors.

All pins are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Register writes are single-cycle strobes and always land.

Top module: `pattern_irq_unit`

## Requirements
- R1: After reset, `int_pending` and `int_req` are 0 and `int_vector` is 0x00. Every configuration register also resets to 0.
- R2: Each bit i is classified by the triple (mask[i], trans[i], pol[i]):
  - 0,0,x: ignored.
  - 1,0,0: level 0 required.
  - 1,0,1: level 1 required.
  - 0,1,0: falling edge required.
  - 0,1,1: rising edge required.
  - 1,1,x: any change required.
  
  Edges compare the current sample with the previous sample.
- R3: Bit i of the invert register (address 3) complements port bit i before any comparison.
- R4: With control bit 1 = 0 (OR mode), a match occurs when at least one specified bit meets its condition.
- R5: With control bit 1 = 1 (AND mode), a match occurs only when every specified bit meets its condition in the same sample.
- R6: When no bit is specified (mask and trans both zero), no match ever occurs, whatever the port does.
- R7: `int_pending` rises at the second rising clock edge after the port value that completes a match is presented. It then stays at 1 until acknowledged.
- R8: A 1 on `int_ack` clears `int_pending` at the next edge. The acknowledge wins over a match in the same cycle.
- R9: `int_req` is 1 exactly when `int_pending` is 1 and control bit 0 (enable) is 1.
- R10: On the edge where the pending flag is set from 0, `int_vector` loads the following fields:
  - [7:4] come from base register (address 5) bits [7:4].
  - [3] is 1 when the source bit's condition is an edge condition.
  - [2:0] is the lowest-numbered specified bit that met its condition.
  
  The vector then stays frozen while pending.
- R11: Register addresses on `cfg_addr` are as follows:
  - 0: polarity.
  - 1: transition.
  - 2: mask.
  - 3: invert.
  - 4: control.
  - 5: base.
  
  A write takes effect at the edge where `cfg_we` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_in | input | 8 | Port bits to be watched |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for a write |
| cfg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | Clears the pending flag |
| int_req | output | 1 | Interrupt request (pending and enabled) |
| int_pending | output | 1 | Sticky match flag |
| int_vector | output | 8 | Captured vector: base upper bits and source code |

## Verification
The hardest case to reach is an edge condition judged on a clean previous/current pair. Configuration takes several writes, and level terms can fire partway through it. The bench therefore holds the port steady while it writes every register. It then moves the port in the same cycle it pulses the acknowledge, so the one sample that matters is the one taken after the clear. Bit-by-bit and two-bit sweeps over every condition code, every previous/current pair, both match modes and both inversion settings set the expected flag and vector arithmetically.

// File: rtl/pmi_pkg.sv
package pmi_pkg;

  typedef enum logic [2:0] {
    REG_POL = 3'd0,
    REG_TRN = 3'd1,
    REG_MSK = 3'd2,
    REG_INV = 3'd3,
    REG_CTL = 3'd4,
    REG_VEC = 3'd5
  } reg_sel_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_AND_BIT = 1;

  typedef enum logic [2:0] {
    TERM_OFF,
    TERM_LO,
    TERM_HI,
    TERM_FALL,
    TERM_RISE,
    TERM_ANY
  } term_e;

  function automatic term_e decode_term(input logic m, input logic t, input logic p);
    term_e k;
    case ({m, t})
      2'b00:   k = TERM_OFF;
      2'b10:   k = p ? TERM_HI : TERM_LO;
      2'b01:   k = p ? TERM_RISE : TERM_FALL;
      default: k = TERM_ANY;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/pmi_cfg_regs.sv
module pmi_cfg_regs
  import pmi_pkg::*;
#(
  parameter int W = 8,
  parameter int CODE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [2:0]          addr,
  input  logic [W-1:0]        wdata,
  output logic [W-1:0]        pol_q,
  output logic [W-1:0]        trn_q,
  output logic [W-1:0]        msk_q,
  output logic [W-1:0]        inv_q,
  output logic                en_q,
  output logic                and_q,
  output logic [W-CODE_W-1:0] base_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trn_q  <= '0;
      msk_q  <= '0;
      inv_q  <= '0;
      en_q   <= 1'b0;
      and_q  <= 1'b0;
      base_q <= '0;
    end else if (we) begin
      case (reg_sel_e'(addr))
        REG_POL: pol_q <= wdata;
        REG_TRN: trn_q <= wdata;
        REG_MSK: msk_q <= wdata;
        REG_INV: inv_q <= wdata;
        REG_CTL: begin
          en_q  <= wdata[CTL_EN_BIT];
          and_q <= wdata[CTL_AND_BIT];
        end
        REG_VEC: base_q <= wdata[W-1:CODE_W];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pmi_sampler.sv
module pmi_sampler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_in,
  input  logic [W-1:0] inv,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] prev_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= port_in ^ inv;
      prev_q <= cur_q;
    end
  end

endmodule

// File: rtl/pmi_term.sv
module pmi_term
  import pmi_pkg::*;
(
  input  logic m,
  input  logic t,
  input  logic p,
  input  logic prev,
  input  logic cur,
  output logic spec,
  output logic sat,
  output logic is_edge
);

  term_e kind;

  always_comb begin
    kind    = decode_term(m, t, p);
    spec    = (kind != TERM_OFF);
    is_edge = (kind == TERM_FALL) || (kind == TERM_RISE) || (kind == TERM_ANY);
    case (kind)
      TERM_LO:   sat = !cur;
      TERM_HI:   sat = cur;
      TERM_FALL: sat = prev & !cur;
      TERM_RISE: sat = !prev & cur;
      TERM_ANY:  sat = prev ^ cur;
      default:   sat = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmi_combine.sv
module pmi_combine #(
  parameter int W = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0] spec,
  input  logic [W-1:0] sat,
  input  logic [W-1:0] edge_v,
  input  logic         and_mode,
  output logic         hit,
  output logic [IW:0]  code
);

  logic [W-1:0]  cand;
  logic [IW-1:0] idx;
  logic          edge_f;
  logic          all_ok;

  always_comb begin
    cand   = spec & sat;
    all_ok = &(~spec | sat);
    hit    = and_mode ? ((|spec) & all_ok) : (|cand);
    idx    = '0;
    edge_f = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand[i]) begin
        idx    = IW'(i);
        edge_f = edge_v[i];
      end
    end
    code = {edge_f, idx};
  end

endmodule

// File: rtl/pmi_latch.sv
module pmi_latch #(
  parameter int W = 8,
  parameter int CODE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [CODE_W-1:0]   code,
  input  logic [W-CODE_W-1:0] base,
  input  logic                en,
  input  logic                ack,
  output logic                pending,
  output logic                req,
  output logic [W-1:0]        vector
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      vector  <= '0;
    end else if (ack) begin
      pending <= 1'b0;
    end else if (hit) begin
      pending <= 1'b1;
      if (!pending) vector <= {base, code};
    end
  end

  assign req = pending & en;

endmodule

// File: rtl/pattern_irq_unit.sv
module pattern_irq_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_in,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         int_ack,
  output logic         int_req,
  output logic         int_pending,
  output logic [W-1:0] int_vector
);

  localparam int IW     = $clog2(W);
  localparam int CODE_W = IW + 1;

  logic [W-1:0]        pol_q, trn_q, msk_q, inv_q;
  logic                en_q, and_q;
  logic [W-CODE_W-1:0] base_q;
  logic [W-1:0]        cur_q, prev_q;
  logic [W-1:0]        spec_v, sat_v, edge_v;
  logic                hit_w;
  logic [CODE_W-1:0]   code_w;

  pmi_cfg_regs #(.W(W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pol_q(pol_q), .trn_q(trn_q), .msk_q(msk_q), .inv_q(inv_q),
    .en_q(en_q), .and_q(and_q), .base_q(base_q)
  );

  pmi_sampler #(.W(W)) u_samp (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .inv(inv_q),
    .cur_q(cur_q), .prev_q(prev_q)
  );

  for (genvar g = 0; g < W; g++) begin : g_term
    pmi_term u_term (
      .m(msk_q[g]), .t(trn_q[g]), .p(pol_q[g]),
      .prev(prev_q[g]), .cur(cur_q[g]),
      .spec(spec_v[g]), .sat(sat_v[g]), .is_edge(edge_v[g])
    );
  end

  pmi_combine #(.W(W), .IW(IW)) u_comb (
    .spec(spec_v), .sat(sat_v), .edge_v(edge_v), .and_mode(and_q),
    .hit(hit_w), .code(code_w)
  );

  pmi_latch #(.W(W), .CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .code(code_w), .base(base_q),
    .en(en_q), .ack(int_ack),
    .pending(int_pending), .req(int_req), .vector(int_vector)
  );

endmodule

// File: rtl/pmi_checker.sv
module pmi_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         int_ack,
  input logic         int_pending,
  input logic         int_req,
  input logic [W-1:0] int_vector,
  input logic         hit,
  input logic         spec_any
);

  assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !int_pending |-> !int_req);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !int_pending);

  assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pending && !int_ack) |=> int_pending);

  assert_set_by_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pending) |-> $past(hit));

  assert_vector_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pending && !int_ack) |=> $stable(int_vector));

  assert_no_spec_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_any |-> !hit);

endmodule

bind pattern_irq_unit pmi_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_pending(int_pending),
  .int_req(int_req), .int_vector(int_vector), .hit(hit_w),
  .spec_any(|(msk_q | trn_q))
);

// File: tb/pattern_irq_unit_tb.sv
`timescale 1ns/1ps
module pattern_irq_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       int_ack = 1'b0;
  logic       int_req, int_pending;
  logic [7:0] int_vector;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pattern_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .int_ack(int_ack),
    .int_req(int_req), .int_pending(int_pending), .int_vector(int_vector)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R11 register addresses: 0 pol, 1 trans, 2 mask, 3 invert, 4 control, 5 base
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // per-bit condition from R2: 0 unspecified, 1 specified but unmet, 2 met
  function automatic int cond(input bit m, input bit t, input bit p, input bit pv, input bit cv);
    case ({m, t, p})
      3'b000, 3'b001: return 0;
      3'b100: return (cv == 1'b0) ? 2 : 1;
      3'b101: return (cv == 1'b1) ? 2 : 1;
      3'b010: return (pv && !cv) ? 2 : 1;
      3'b011: return (!pv && cv) ? 2 : 1;
      default: return (pv != cv) ? 2 : 1;
    endcase
  endfunction

  task automatic run_vec(input logic [7:0] pol, input logic [7:0] trn, input logic [7:0] msk,
                         input logic [7:0] inv, input bit andm, input bit en,
                         input logic [7:0] base, input logic [7:0] pp, input logic [7:0] cp,
                         input string req);
    int nspec, nmet, first;
    bit exp_hit;
    logic [7:0] exp_vec;
    nspec = 0; nmet = 0; first = -1;
    for (int i = 0; i < 8; i++) begin
      int c;
      c = cond(msk[i], trn[i], pol[i], pp[i] ^ inv[i], cp[i] ^ inv[i]);
      if (c > 0) nspec++;
      if (c == 2) begin
        nmet++;
        if (first < 0) first = i;
      end
    end
    exp_hit = andm ? (nspec > 0 && nmet == nspec) : (nmet > 0);
    exp_vec = {base[7:4], (first >= 0) ? trn[first] : 1'b0, 3'(first)};
    port_in = pp;
    wr(3'd0, pol); wr(3'd1, trn); wr(3'd2, msk); wr(3'd3, inv);
    wr(3'd4, {6'd0, andm, en}); wr(3'd5, base);
    tick(); tick();
    port_in = cp; int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
    tick();
    chk(req, int_pending, exp_hit);
    chk("R9", int_req, exp_hit & en);
    if (exp_hit) chk("R10", int_vector, exp_vec);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] bm;
    port_in = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int_pending, 1'b0);
    chk("R1", int_req, 1'b0);
    chk("R1", int_vector, 8'h00);
    rst_n = 1'b1;
    tick();

    // R6: nothing specified, port toggles, no pending
    for (int k = 0; k < 8; k++) begin
      port_in = 8'(k * 8'h35);
      tick();
    end
    chk("R6", int_pending, 1'b0);
    chk("R6", int_vector, 8'h00);

    // R2/R3/R4 single-bit sweep over all codes, positions, inversion, prev/cur pairs
    for (int b = 0; b < 8; b++)
      for (int k = 0; k < 8; k++)
        for (int iv = 0; iv < 2; iv++)
          for (int tr = 0; tr < 4; tr++) begin
            logic [7:0] pp, cp;
            bm = 8'(1 << b);
            pp = (8'hA5 & ~bm) | (tr[1] ? bm : 8'h00);
            cp = (8'h3C & ~bm) | (tr[0] ? bm : 8'h00);
            run_vec(k[0] ? bm : 8'h00, k[1] ? bm : 8'h00, k[2] ? bm : 8'h00,
                    iv[0] ? bm : 8'h00, 1'b0, tr[0], 8'((b * 3 + k) << 4),
                    pp, cp, iv[0] ? "R3" : "R2");
          end

    // R4/R5 two-bit sweep over bits 1 and 6 in both modes
    for (int md = 0; md < 2; md++)
      for (int ka = 0; ka < 8; ka++)
        for (int kb = 0; kb < 8; kb++)
          for (int pv = 0; pv < 4; pv++)
            for (int cv = 0; cv < 4; cv++) begin
              logic [7:0] pol, trn, msk;
              pol = {1'b0, kb[0], 4'b0, ka[0], 1'b0};
              trn = {1'b0, kb[1], 4'b0, ka[1], 1'b0};
              msk = {1'b0, kb[2], 4'b0, ka[2], 1'b0};
              run_vec(pol, trn, msk, 8'h00, md[0], 1'b1, 8'((ka + kb) << 4),
                      {1'b0, pv[1], 4'b0, pv[0], 1'b0}, {1'b0, cv[1], 4'b0, cv[0], 1'b0},
                      md[0] ? "R5" : "R4");
            end

    // R7/R10 sticky flag and frozen vector, R8 ack priority
    int_ack = 1'b1; port_in = 8'h01;
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h01);
    wr(3'd4, 8'h01); wr(3'd5, 8'hC0);
    int_ack = 1'b0;
    wr(3'd2, 8'h01);           // bit 0 must be level 1: match from here on
    tick();
    chk("R7", int_pending, 1'b1);
    chk("R10", int_vector, 8'hC0);
    wr(3'd5, 8'h70);
    wr(3'd2, 8'h09); wr(3'd0, 8'h09);
    port_in = 8'h09;
    tick(); tick();
    chk("R7", int_pending, 1'b1);
    chk("R10", int_vector, 8'hC0);
    int_ack = 1'b1;
    tick();
    chk("R8", int_pending, 1'b0);
    int_ack = 1'b0;
    tick();
    chk("R8", int_pending, 1'b1);
    chk("R10", int_vector, 8'h70);
    chk("R9", int_req, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule